// File: doc/BRIEF.md
# FP4 E2M1 to FP32 Widening Converter

This block widens a packed vector of 4-bit E2M1 floating-point codes into IEEE-754 single-precision words. Each 4-bit code carries one sign bit, a two-bit exponent and a one-bit mantissa. The format has no infinity and no NaN codes. Every lane is converted on its own, and all lanes are converted in the same cycle. The results come out of one register stage, together with a valid strobe.

Codes with a nonzero exponent are rebased onto the single-precision exponent by a fixed offset. The exponent-zero codes are mapped straight to literal constants: zero, or one half. The sign is kept in both cases, so negative zero and negative one half can be produced.

Top module: `fp4_widen`

## Requirements
- R1: Input code bits are sign = bit 3, exponent = bits 2:1, mantissa = bit 0. For lane k, the code is `codes_i[4k+3:4k]` and the result is `words_o[32k+31:32k]`.
- R2: The magnitudes for codes 0..7 (sign clear) are 0.0, 0.5, 1.0, 1.5, 2.0, 3.0, 4.0 and 6.0. In FP32 these are 0x00000000, 0x3F000000, 0x3F800000, 0x3FC00000, 0x40000000, 0x40400000, 0x40800000 and 0x40C00000.
- R3: For a nonzero exponent field, the FP32 exponent field (bits 30:23) equals the code exponent plus 126. The mantissa bit goes to FP32 bit 22, and bits 21:0 are zero.
- R4: The code sign bit appears on FP32 bit 31 for all codes, including the exponent-zero codes. Code 1000 gives 0x80000000 and code 1001 gives 0xBF000000.
- R5: An exponent field of 0 gives zero when the mantissa is 0 and ±0.5 when the mantissa is 1.
- R6: `valid_o` equals `valid_i` delayed by one clock. `words_o` updates one clock after a cycle with `valid_i` high, and holds its value otherwise.
- R7: Lanes are independent. Each lane's result depends only on that lane's code, in the same cycle.
- R8: While `rst_ni` is low, `valid_o` is 0 and `words_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input codes are valid |
| codes_i | input | 4*LANES | Packed E2M1 codes, lane 0 in the low bits |
| valid_o | output | 1 | Output words are valid |
| words_o | output | 32*LANES | Packed FP32 results, lane 0 in the low bits |

## Verification
Faults in the per-lane mapping show up on the output one cycle after the input is accepted. A wrong exponent offset, sign path or exponent-zero constant gives a wrong bit pattern in the affected lane. A bad hold enable shows up as the output changing on a cycle where `valid_i` is low. A broken valid pipeline shows up as `valid_o` misaligned with the input strobe in the very next cycle. Sweeping every code through every lane, in several different lane arrangements, exposes lane crosstalk and ordering mistakes at once.

// File: rtl/fp4_widen_pkg.sv
package fp4_widen_pkg;
  localparam int CODE_W = 4;
  localparam int WORD_W = 32;
  localparam int EXP_OFFSET = 126;

  typedef struct packed {
    logic       sign;
    logic [1:0] expo;
    logic       man;
  } e2m1_t;
endpackage

// File: rtl/fp4_lane_conv.sv
module fp4_lane_conv
  import fp4_widen_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  e2m1_t c;
  logic [7:0] exp_f;

  assign c = e2m1_t'(code_i);

  always_comb begin
    exp_f  = 8'(EXP_OFFSET) + {6'd0, c.expo};
    word_o = '0;
    if (c.expo != 2'd0) begin
      word_o = {c.sign, exp_f, c.man, 22'd0};
    end else if (c.man) begin
      word_o = {c.sign, 31'h3F000000};  // +-0.5
    end else begin
      word_o = {c.sign, 31'd0};         // +-0.0
    end
  end

  always_comb begin
    assert_sign_R4: assert (word_o[31] == code_i[3]);
    assert_frac_zero_R3: assert (word_o[21:0] == 22'd0);
  end
endmodule

// File: rtl/fp4_widen.sv
module fp4_widen
  import fp4_widen_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [CODE_W*LANES-1:0] codes_i,
  output logic                    valid_o,
  output logic [WORD_W*LANES-1:0] words_o
);
  localparam int OUT_W = WORD_W * LANES;

  logic [OUT_W-1:0] words_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fp4_lane_conv u_conv (
      .code_i(codes_i[CODE_W*k +: CODE_W]),
      .word_o(words_d[WORD_W*k +: WORD_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      words_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) words_o <= words_d;
    end
  end

  assert_valid_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(words_o));
  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> words_o == $past(words_d));
endmodule

// File: tb/tb_fp4_widen.sv
module tb_fp4_widen;
  localparam int LANES = 4;

  logic clk_i = 0;
  logic rst_ni = 0;
  logic valid_i = 0;
  logic [4*LANES-1:0]  codes_i = '0;
  logic                valid_o;
  logic [32*LANES-1:0] words_o;

  int total = 0;
  int bad = 0;
  logic [32*LANES-1:0] exp_q[$];

  always #4 clk_i = ~clk_i;

  fp4_widen #(.LANES(LANES)) dut (.*);

  function automatic logic [31:0] ref_word(input logic [3:0] c);
    logic [31:0] mag;
    case (c[2:0])
      3'd0: mag = 32'h00000000;
      3'd1: mag = 32'h3F000000;
      3'd2: mag = 32'h3F800000;
      3'd3: mag = 32'h3FC00000;
      3'd4: mag = 32'h40000000;
      3'd5: mag = 32'h40400000;
      3'd6: mag = 32'h40800000;
      default: mag = 32'h40C00000;
    endcase
    return {c[3], mag[30:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4*LANES-1:0] c);
    logic [32*LANES-1:0] e;
    for (int k = 0; k < LANES; k++) e[32*k +: 32] = ref_word(c[4*k +: 4]);
    @(negedge clk_i);
    valid_i = 1;
    codes_i = c;
    exp_q.push_back(e);
    @(negedge clk_i);
    valid_i = 0;
  endtask

  // Monitor: sample after the edge, at negedge.
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected", 128'(words_o), 0);
        else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          chk(words_o === e, "R1 R2 R3 R4 R5 R7 lanes", words_o, e);
        end
      end
    end
  end

  initial begin
    #200000;
    chk(0, "watchdog", 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] held;
    #1;
    chk(valid_o === 0 && words_o === '0, "R8 reset", {valid_o, words_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R2 R4 R5: all 16 codes in every lane
    for (int c = 0; c < 16; c++) drive({4{4'(c)}});
    // R7: distinct codes per lane
    for (int c = 0; c < 16; c++)
      drive({4'(c), 4'(c + 5), 4'(c + 9), 4'(15 - c)});
    // R4 explicit
    drive(16'h9898);
    @(negedge clk_i);
    chk(words_o[31:0] === 32'h80000000 && words_o[63:32] === 32'hBF000000,
        "R4 negative zero/half", words_o, 0);
    // R3: exponent field check for code 0111
    drive(16'h7777);
    @(negedge clk_i);
    chk(words_o[30:23] === 8'd129 && words_o[22] === 1'b1, "R3 exp rebase",
        words_o[31:0], 32'h40C00000);
    // R6: hold while valid_i low, and valid_o low
    held = words_o;
    @(negedge clk_i);
    codes_i = 16'h1234;
    repeat (3) @(negedge clk_i);
    chk(words_o === held, "R6 hold", words_o, held);
    chk(valid_o === 0, "R6 valid delay", 128'(valid_o), 0);
    // R6: back-to-back valid
    @(negedge clk_i);
    valid_i = 1; codes_i = 16'h2222;
    exp_q.push_back({4{ref_word(4'h2)}});
    @(negedge clk_i);
    codes_i = 16'hDDDD;
    exp_q.push_back({4{ref_word(4'hD)}});
    @(negedge clk_i);
    valid_i = 0;
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 queue drained", 128'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule